// File: doc/BRIEF.md
# Masked Data Watchpoint Comparator

This block watches the load/store address stream of a processor core and flags accesses that fall inside regions set up by a debugger. It holds a small number of watch slots. Each slot keeps a 32-bit base address and a control word with a load-arm bit, a store-arm bit and a six-bit mask field. Every address presented with its direction is compared against all armed slots in the same cycle. A hit comes out combinationally, so the core can hold the access before it commits. A registered one-cycle debug request then follows and carries the index of the slot that hit.

The low six mask bits come from the control word, and every bit above them is forced to one. A set mask bit means the address bit is compared. A cleared mask bit means it is ignored. A region is therefore aligned and covers (inverted mask + 1) bytes. If the field has holes, the block repairs it. The working mask becomes ones from bit 31 down to the first cleared bit and zeros below it. A per-slot flag shows that this repair took place.

Top module: `data_watch_cmp`

## Requirements
- R1: After reset both slot registers of every slot are zero, and `hit`, `dbg_req`, `hit_slot`, `dbg_slot` and `mask_norm` are all zero.
- R2: A slot whose load-arm bit (control bit 30) and store-arm bit (control bit 31) are both clear never matches, whatever its address and mask.
- R3: A slot with only the store-arm bit set matches write accesses (`acc_write`=1) and no reads. A slot with only the load-arm bit set matches reads (`acc_write`=0) and no writes.
- R4: The working mask is control bits [5:0] with ones in bits [31:6]. An armed slot matches when `acc_addr & mask` equals `slot_addr & mask`.
- R5: If the inverted working mask is not one less than a power of two, the mask used becomes ones from bit 31 down to, but not including, its highest cleared bit, and zeros below. `mask_norm[i]` is then 1 for that slot and 0 otherwise.
- R6: When several slots match the same access, `hit_slot` and `dbg_slot` report the lowest matching slot index.
- R7: `hit` and `hit_slot` follow the current access in the same cycle. `dbg_req` is high in the cycle after a hit and low in the cycle after a non-hit, and `dbg_slot` holds the `hit_slot` of that earlier cycle.
- R8: A write with `cfg_we`=1 goes to slot `cfg_slot`. `cfg_sel`=0 selects the address register and `cfg_sel`=1 the control register. The new value takes effect from the next cycle on.
- R9: With `acc_valid` low there is no hit, and `dbg_req` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Slot register write strobe |
| cfg_slot | input | 1 | Slot index for the write |
| cfg_sel | input | 1 | 0 = address register, 1 = control register |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | A load/store address is presented |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Access address |
| hit | output | 1 | Combinational match for the current access |
| hit_slot | output | 1 | Lowest matching slot for the current access |
| dbg_req | output | 1 | Registered debug request, one cycle after a hit |
| dbg_slot | output | 1 | Slot index carried with the debug request |
| mask_norm | output | 2 | Per-slot flag: the mask field was repaired |

## Verification
On every cycle the assertions check three things: the timing link between a hit and the registered request, including the slot index it carries; that the request stays low after idle cycles; and that every slot's working mask is contiguous. Only the bench's scenarios can show the rest. That covers which region, direction and slot actually match, the exact truncated mask chosen for a field with holes, lowest-index priority, and the rule that disarmed slots stay silent. The bench checks these against its own model of the mask and match rules.

// File: rtl/data_watch_cmp.sv
module data_watch_cmp #(
  parameter int NSLOT  = 2,
  parameter int AW     = 32,
  parameter int MW     = 6,
  parameter int LD_BIT = 30,
  parameter int ST_BIT = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [((NSLOT>1)?$clog2(NSLOT):1)-1:0] cfg_slot,
  input  logic                 cfg_sel,
  input  logic [AW-1:0]        cfg_wdata,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic [AW-1:0]        acc_addr,
  output logic                 hit,
  output logic [((NSLOT>1)?$clog2(NSLOT):1)-1:0] hit_slot,
  output logic                 dbg_req,
  output logic [((NSLOT>1)?$clog2(NSLOT):1)-1:0] dbg_slot,
  output logic [NSLOT-1:0]     mask_norm
);
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [AW-1:0] base_q [NSLOT];
  logic [AW-1:0] ctrl_q [NSLOT];
  logic [AW-1:0] mask_w [NSLOT];
  logic [NSLOT-1:0] match;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [AW-1:0] raw, inv, trunc;
    logic          holes, arm_ok;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        ctrl_q[i] <= '0;
      end else if (cfg_we && cfg_slot == SW'(i)) begin
        if (cfg_sel) ctrl_q[i] <= cfg_wdata;
        else         base_q[i] <= cfg_wdata;
      end
    end

    assign raw   = {{(AW-MW){1'b1}}, ctrl_q[i][MW-1:0]};
    assign inv   = ~raw;
    assign holes = |((inv + AW'(1)) & inv);

    for (genvar k = 0; k < AW; k++) begin : g_bit
      assign trunc[k] = &raw[AW-1:k];
    end

    assign mask_w[i]    = holes ? trunc : raw;
    assign mask_norm[i] = holes;
    assign arm_ok = acc_write ? ctrl_q[i][ST_BIT] : ctrl_q[i][LD_BIT];
    assign match[i] = acc_valid && arm_ok &&
                      ((acc_addr & mask_w[i]) == (base_q[i] & mask_w[i]));

    AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      ((((~mask_w[i]) + AW'(1)) & (~mask_w[i])) == '0)); // R5
  end

  always_comb begin
    hit_slot = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (match[i]) hit_slot = SW'(i);
  end

  assign hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_req  <= 1'b0;
      dbg_slot <= '0;
    end else begin
      dbg_req  <= hit;
      dbg_slot <= hit ? hit_slot : '0;
    end
  end

  AST_REQ_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> dbg_req); // R7
  AST_NO_REQ_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !dbg_req); // R7
  AST_SLOT_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> dbg_slot == $past(hit_slot)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !dbg_req); // R9
endmodule

// File: tb/data_watch_cmp_test.sv
module data_watch_cmp_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_slot = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [31:0] acc_addr = 0;
  logic hit, hit_slot, dbg_req, dbg_slot;
  logic [1:0] mask_norm;
  int checks = 0, fails = 0;
  logic [31:0] m_base [2];
  logic [31:0] m_ctrl [2];

  always #4 clk = ~clk;

  data_watch_cmp uut (.clk, .rst_n, .cfg_we, .cfg_slot, .cfg_sel, .cfg_wdata,
    .acc_valid, .acc_write, .acc_addr, .hit, .hit_slot, .dbg_req, .dbg_slot,
    .mask_norm);

  function automatic logic [31:0] ref_mask(input logic [31:0] c);
    logic [31:0] m = {26'h3ffffff, c[5:0]};
    logic [31:0] inv = ~m;
    logic [31:0] f = 0;
    logic gap = 0;
    if (((inv + 1) & inv) == 0) return m;
    for (int k = 31; k >= 0; k--) begin
      if (!gap && m[k]) f[k] = 1'b1;
      else gap = 1'b1;
    end
    return f;
  endfunction

  function automatic logic ref_holes(input logic [31:0] c);
    logic [31:0] inv = ~{26'h3ffffff, c[5:0]};
    return ((inv + 1) & inv) != 0;
  endfunction

  function automatic logic ref_match(input int s, input logic [31:0] a, input logic w);
    logic [31:0] m = ref_mask(m_ctrl[s]);
    logic arm = w ? m_ctrl[s][31] : m_ctrl[s][30];
    return arm && ((a & m) == (m_base[s] & m));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input int s, input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_slot = s[0]; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (sel) m_ctrl[s] = d; else m_base[s] = d;
  endtask

  task automatic access(input string req, input logic v, input logic [31:0] a, input logic w);
    logic e0, e1, eh;
    logic es;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_write = w;
    e0 = v && ref_match(0, a, w);
    e1 = v && ref_match(1, a, w);
    eh = e0 | e1;
    es = !e0 && e1;
    #1;
    chk({req, " hit"}, 32'(hit), 32'(eh));
    if (eh) chk({req, " hit_slot R6"}, 32'(hit_slot), 32'(es));
    @(negedge clk);
    acc_valid = 0;
    chk({req, " dbg_req R7"}, 32'(dbg_req), 32'(eh));
    if (eh) chk({req, " dbg_slot R7"}, 32'(dbg_slot), 32'(es));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_base[0] = 0; m_base[1] = 0; m_ctrl[0] = 0; m_ctrl[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 hit", 32'(hit), 0);
    chk("R1 dbg_req", 32'(dbg_req), 0);
    chk("R1 mask_norm", 32'(mask_norm), 0);
    access("R1 zero slots address 0", 1, 32'h0, 1);
    access("R2 disarmed", 1, 32'h0, 0);

    cfg(0, 0, 32'h0000_1000);
    cfg(0, 1, 32'h8000_0030);
    access("R3 store on store-armed", 1, 32'h0000_100c, 1);
    access("R3 load on store-armed", 1, 32'h0000_100c, 0);
    access("R4 outside region", 1, 32'h0000_1010, 1);
    access("R9 idle", 0, 32'h0000_1000, 1);
    cfg(0, 1, 32'h4000_0030);
    access("R3 load on load-armed", 1, 32'h0000_100f, 0);
    access("R3 store on load-armed", 1, 32'h0000_100f, 1);
    cfg(0, 1, 32'h0000_0000);
    access("R2 cleared arms", 1, 32'h0000_1000, 0);

    cfg(0, 1, 32'hC000_0035);
    #1 chk("R5 mask_norm set", 32'(mask_norm), 32'b01);
    access("R5 truncated mask match", 1, 32'h0000_100a, 1);
    access("R5 truncated mask miss", 1, 32'h0000_1010, 1);
    cfg(0, 1, 32'hC000_003C);
    #1 chk("R5 contiguous no flag", 32'(mask_norm), 0);

    cfg(1, 0, 32'h0000_1000);
    cfg(1, 1, 32'hC000_0000);
    cfg(0, 1, 32'hC000_0020);
    access("R6 both match", 1, 32'h0000_1000, 0);
    access("R6 slot1 only", 1, 32'h0000_1020, 0);
    cfg(1, 0, 32'h0000_2000);
    access("R8 new base slot1", 1, 32'h0000_2010, 1);

    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 7) == 0) begin
        int s = $urandom_range(0, 1);
        cfg(s, 1, {$urandom_range(0, 3) == 0 ? 2'b00 : 2'($urandom), 24'h0, 6'($urandom)});
        #1 chk("R5 random flag", 32'(mask_norm[s]), 32'(ref_holes(m_ctrl[s])));
      end
      begin
        int s = $urandom_range(0, 1);
        access("R4 random", $urandom_range(0, 9) != 0,
               m_base[s] ^ 32'($urandom_range(0, 63)) ^ ($urandom_range(0, 5) == 0 ? 32'h100 : 0),
               1'($urandom));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule